// File: doc/BRIEF.md
# Off-Mode Wakeup Power Sequencer

This block brings a chip out of its deepest power-down state once a wake-up arrives from the I/O wake-up chain. It first starts the reference oscillator and raises the clock request. Next it enables the wake-up regulator. After the regulator ramp it drops the external off-mode request, so the external power IC restores both supply rails with no serial commands. Two settling windows then run side by side, one for the oscillator and one for the rails. When both have closed, a single step powers the processor and core domains, restarts their memory regulators and enables the analog cells, with both domain resets still held.

The core reset is released when a programmable hold window expires. The processor reset is also released at that point, but only if the pads have returned from their off setting. The pads return to normal only while the pad override bit is 1. Each window length comes from a 16-bit setting counted in clock cycles. A setting of zero gives a one-cycle window. The regulator ramp ends either on an acknowledge input or on a programmable timeout.

Top module: `offwake_seq`

## Requirements
- R1: A synchronous reset (`rst` high) leaves the block in state code 0 (off): `osc_en`, `clk_req`, `wkreg_en`, `dom_pwr_on`, `mem_reg_on`, `analog_on`, `pad_normal` and `seq_done` are 0, while `off_mode_req`, `core_rst` and `mpu_rst` are 1.
- R2: In state 0, a `wake_evt` seen at a clock edge starts the sequence only when `io_wake_en` and `io_chain_en` are both 1. If either bit is 0, the state stays 0 and every output keeps its off value.
- R3: The accepted wake-up moves the block to state 1 for exactly one cycle, with `osc_en` and `clk_req` high. State 2 follows and adds `wkreg_en`. `off_mode_req` stays 1 until state 3 is entered, and then it falls.
- R4: With `ramp_use_ack` = 1, state 2 lasts until `ramp_ack` is seen high, and state 3 appears in the next cycle. With `ramp_use_ack` = 0, state 2 lasts w(`ramp_tmo_cyc`) cycles, where w(n) = n for n ≥ 1 and w(0) = 1.
- R5: The oscillator and rail windows both start on entry to state 3. State 3 lasts max(w(`osc_setup_cyc`), w(`rail_setup_cyc`)) cycles.
- R6: In the first cycle of state 4, `dom_pwr_on`, `mem_reg_on` and `analog_on` are all 1 and `mpu_rst` is 1. In the last cycle of state 3 all three are 0.
- R7: `pad_normal` can only become 1 from state 4 onward, and only while `pad_ovr` is 1. If `pad_ovr` is already 1 on entry to state 4, `pad_normal` is 1 in the first cycle of state 4. If `pad_ovr` is set later, `pad_normal` rises one cycle after it is seen.
- R8: `core_rst` falls in cycle w(`rst_hold_cyc`) of state 4. The block moves to state 5, which drops `mpu_rst`, only once that window has expired and `pad_normal` is 1. With `pad_ovr` held at 1, state 4 lasts w(`rst_hold_cyc`) cycles.
- R9: `seq_done` is high for exactly the first cycle of state 5.
- R10: A `wake_evt` arriving in states 1 through 5 has no effect on the state sequence, its durations or `seq_done`.
- R11: `state_o` encodes the states as follows: 0 off, 1 oscillator start, 2 regulator ramp, 3 settling, 4 reset hold, 5 running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wake_evt | input | 1 | Wake-up from the I/O chain |
| io_wake_en | input | 1 | I/O wake enable bit |
| io_chain_en | input | 1 | I/O chain enable bit |
| osc_setup_cyc | input | 16 | Oscillator settling window, in cycles |
| rail_setup_cyc | input | 16 | Supply-rail settling window, in cycles |
| rst_hold_cyc | input | 16 | Domain reset hold window, in cycles |
| ramp_tmo_cyc | input | 16 | Regulator ramp timeout, in cycles |
| ramp_use_ack | input | 1 | 1: end the ramp on `ramp_ack`; 0: end it on the timeout |
| ramp_ack | input | 1 | Regulator ramp complete |
| pad_ovr | input | 1 | Pad override bit; 1 allows the pads to return to normal |
| osc_en | output | 1 | Oscillator enable |
| clk_req | output | 1 | Clock request |
| wkreg_en | output | 1 | Wake-up regulator enable |
| off_mode_req | output | 1 | External off-mode request, 1 = rails off |
| dom_pwr_on | output | 1 | Processor and core domain power |
| mem_reg_on | output | 1 | Memory regulator restart |
| analog_on | output | 1 | Analog cell enable on both rails |
| core_rst | output | 1 | Core domain reset, 1 = held |
| mpu_rst | output | 1 | Processor domain reset, 1 = held |
| pad_normal | output | 1 | 1 = pads in normal configuration |
| state_o | output | 3 | State code |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
The full sequence is run with the oscillator window longer than the rail window, then with the rail window longer, and then with every setting at zero. This shows whether the settling step waits for the later window, and whether a zero setting still gives exactly one cycle. The ramp is ended once by its acknowledge and once by its timeout, which separates the two exit paths. A run with the pad override held at 0 isolates the pad condition: the core reset must be released while the processor reset stays held. Wake-ups are applied with one enable bit cleared, and again while a sequence is busy, to show that both are ignored.

// File: rtl/owk_pkg.sv
package owk_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_OSC    = 3'd1,
    ST_RAMP   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_HOLD   = 3'd4,
    ST_RUN    = 3'd5
  } owk_state_e;

  localparam int NUM_TMR  = 4;
  localparam int TMR_RAMP = 0;
  localparam int TMR_OSC  = 1;
  localparam int TMR_RAIL = 2;
  localparam int TMR_RST  = 3;

  typedef struct packed {
    logic osc_en;
    logic clk_req;
    logic wkreg_en;
    logic off_req;
    logic dom_pwr;
    logic mem_reg;
    logic analog;
    logic core_rst;
    logic mpu_rst;
  } owk_ctl_t;

  // Effective window length in cycles for a programmed count.
  function automatic int unsigned owk_win(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  // The chain is armed only when both software enables are set.
  function automatic logic owk_armed(input logic wake_en, input logic chain_en);
    return wake_en & chain_en;
  endfunction

  // Output levels for each state; core reset is freed once its window ends.
  function automatic owk_ctl_t owk_decode(input owk_state_e s, input logic rst_exp);
    owk_ctl_t c;
    c          = '0;
    c.off_req  = 1'b1;
    c.core_rst = 1'b1;
    c.mpu_rst  = 1'b1;
    case (s)
      ST_OSC: begin
        c.osc_en  = 1'b1;
        c.clk_req = 1'b1;
      end
      ST_RAMP: begin
        c.osc_en   = 1'b1;
        c.clk_req  = 1'b1;
        c.wkreg_en = 1'b1;
      end
      ST_SETTLE: begin
        c.osc_en   = 1'b1;
        c.clk_req  = 1'b1;
        c.wkreg_en = 1'b1;
        c.off_req  = 1'b0;
      end
      ST_HOLD: begin
        c.osc_en   = 1'b1;
        c.clk_req  = 1'b1;
        c.wkreg_en = 1'b1;
        c.off_req  = 1'b0;
        c.dom_pwr  = 1'b1;
        c.mem_reg  = 1'b1;
        c.analog   = 1'b1;
        c.core_rst = ~rst_exp;
      end
      ST_RUN: begin
        c.osc_en   = 1'b1;
        c.clk_req  = 1'b1;
        c.wkreg_en = 1'b1;
        c.off_req  = 1'b0;
        c.dom_pwr  = 1'b1;
        c.mem_reg  = 1'b1;
        c.analog   = 1'b1;
        c.core_rst = 1'b0;
        c.mpu_rst  = 1'b0;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/owk_timer.sv
module owk_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  // Counts down to 1 and holds there; the window is max(n,1) cycles long.
  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q > ONE)
      cnt_q <= cnt_q - ONE;
  end

  assign expired = (cnt_q <= ONE);
endmodule

// File: rtl/owk_fsm.sv
module owk_fsm
  import owk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wake_evt,
  input  logic               io_wake_en,
  input  logic               io_chain_en,
  input  logic               ramp_use_ack,
  input  logic               ramp_ack,
  input  logic               pad_ovr,
  input  logic [NUM_TMR-1:0] tmr_exp,
  output owk_state_e         state_q,
  output logic [NUM_TMR-1:0] tmr_load,
  output logic               pad_norm_q,
  output logic               done_q,
  output logic               wake_take,
  output logic               ramp_fin,
  output logic               settle_join,
  output logic               hold_fin
);
  owk_state_e nxt;

  assign wake_take   = wake_evt & owk_armed(io_wake_en, io_chain_en);
  assign ramp_fin    = ramp_use_ack ? ramp_ack : tmr_exp[TMR_RAMP];
  assign settle_join = tmr_exp[TMR_OSC] & tmr_exp[TMR_RAIL];
  assign hold_fin    = tmr_exp[TMR_RST] & pad_norm_q;

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_OFF:    if (wake_take)   nxt = ST_OSC;
      ST_OSC:                     nxt = ST_RAMP;
      ST_RAMP:   if (ramp_fin)    nxt = ST_SETTLE;
      ST_SETTLE: if (settle_join) nxt = ST_HOLD;
      ST_HOLD:   if (hold_fin)    nxt = ST_RUN;
      ST_RUN:                     nxt = ST_RUN;
      default:                    nxt = ST_OFF;
    endcase
  end

  always_comb begin
    tmr_load           = '0;
    tmr_load[TMR_RAMP] = (state_q == ST_OSC);
    tmr_load[TMR_OSC]  = (state_q == ST_RAMP) & ramp_fin;
    tmr_load[TMR_RAIL] = (state_q == ST_RAMP) & ramp_fin;
    tmr_load[TMR_RST]  = (state_q == ST_SETTLE) & settle_join;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OFF;
      pad_norm_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= nxt;
      pad_norm_q <= pad_norm_q | (pad_ovr & ((nxt == ST_HOLD) | (nxt == ST_RUN)));
      done_q     <= (state_q == ST_HOLD) & hold_fin;
    end
  end
endmodule

// File: rtl/owk_outdec.sv
module owk_outdec
  import owk_pkg::*;
(
  input  owk_state_e state_q,
  input  logic       rst_exp,
  output owk_ctl_t   ctl
);
  assign ctl = owk_decode(state_q, rst_exp);
endmodule

// File: rtl/offwake_seq.sv
module offwake_seq
  import owk_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wake_evt,
  input  logic          io_wake_en,
  input  logic          io_chain_en,
  input  logic [CW-1:0] osc_setup_cyc,
  input  logic [CW-1:0] rail_setup_cyc,
  input  logic [CW-1:0] rst_hold_cyc,
  input  logic [CW-1:0] ramp_tmo_cyc,
  input  logic          ramp_use_ack,
  input  logic          ramp_ack,
  input  logic          pad_ovr,
  output logic          osc_en,
  output logic          clk_req,
  output logic          wkreg_en,
  output logic          off_mode_req,
  output logic          dom_pwr_on,
  output logic          mem_reg_on,
  output logic          analog_on,
  output logic          core_rst,
  output logic          mpu_rst,
  output logic          pad_normal,
  output logic [2:0]    state_o,
  output logic          seq_done
);
  logic [CW-1:0]      tmr_val [NUM_TMR];
  logic [NUM_TMR-1:0] tmr_load;
  logic [NUM_TMR-1:0] tmr_exp;
  owk_state_e         state_q;
  owk_ctl_t           ctl;
  logic               pad_norm_q, done_q;
  logic               wake_take, ramp_fin, settle_join, hold_fin;
  logic               osc_exp, rail_exp, rst_exp;

  assign tmr_val[TMR_RAMP] = ramp_tmo_cyc;
  assign tmr_val[TMR_OSC]  = osc_setup_cyc;
  assign tmr_val[TMR_RAIL] = rail_setup_cyc;
  assign tmr_val[TMR_RST]  = rst_hold_cyc;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    owk_timer #(.W(CW)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load[i]),
      .load_val (tmr_val[i]),
      .expired  (tmr_exp[i])
    );
  end

  assign osc_exp  = tmr_exp[TMR_OSC];
  assign rail_exp = tmr_exp[TMR_RAIL];
  assign rst_exp  = tmr_exp[TMR_RST];

  owk_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wake_evt     (wake_evt),
    .io_wake_en   (io_wake_en),
    .io_chain_en  (io_chain_en),
    .ramp_use_ack (ramp_use_ack),
    .ramp_ack     (ramp_ack),
    .pad_ovr      (pad_ovr),
    .tmr_exp      (tmr_exp),
    .state_q      (state_q),
    .tmr_load     (tmr_load),
    .pad_norm_q   (pad_norm_q),
    .done_q       (done_q),
    .wake_take    (wake_take),
    .ramp_fin     (ramp_fin),
    .settle_join  (settle_join),
    .hold_fin     (hold_fin)
  );

  owk_outdec u_dec (
    .state_q (state_q),
    .rst_exp (rst_exp),
    .ctl     (ctl)
  );

  assign osc_en       = ctl.osc_en;
  assign clk_req      = ctl.clk_req;
  assign wkreg_en     = ctl.wkreg_en;
  assign off_mode_req = ctl.off_req;
  assign dom_pwr_on   = ctl.dom_pwr;
  assign mem_reg_on   = ctl.mem_reg;
  assign analog_on    = ctl.analog;
  assign core_rst     = ctl.core_rst;
  assign mpu_rst      = ctl.mpu_rst;
  assign pad_normal   = pad_norm_q;
  assign state_o      = state_q;
  assign seq_done     = done_q;
endmodule

// File: rtl/offwake_seq_chk.sv
module offwake_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       io_wake_en,
  input logic       io_chain_en,
  input logic       pad_ovr,
  input logic [2:0] state_o,
  input logic       osc_en,
  input logic       clk_req,
  input logic       wkreg_en,
  input logic       off_mode_req,
  input logic       dom_pwr_on,
  input logic       mem_reg_on,
  input logic       analog_on,
  input logic       core_rst,
  input logic       mpu_rst,
  input logic       pad_normal,
  input logic       seq_done,
  input logic       osc_exp,
  input logic       rail_exp
);
  p_wake_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && !(io_wake_en && io_chain_en)) |=> state_o == 3'd0);

  p_off_order_r3: assert property (@(posedge clk) disable iff (rst)
    !off_mode_req |-> (osc_en && clk_req && wkreg_en));

  p_osc_first_r3: assert property (@(posedge clk) disable iff (rst)
    wkreg_en |-> osc_en);

  p_join_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3 && !(osc_exp && rail_exp)) |=> state_o == 3'd3);

  p_pwr_step_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(dom_pwr_on) |-> (mem_reg_on && analog_on && mpu_rst));

  p_pad_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pad_normal) |-> $past(pad_ovr));

  p_mpu_rel_r8: assert property (@(posedge clk) disable iff (rst)
    !mpu_rst |-> (pad_normal && !core_rst));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    state_o != 3'd0 |=> state_o != 3'd0);

  p_enc_r11: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd5);
endmodule

bind offwake_seq offwake_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .io_wake_en   (io_wake_en),
  .io_chain_en  (io_chain_en),
  .pad_ovr      (pad_ovr),
  .state_o      (state_o),
  .osc_en       (osc_en),
  .clk_req      (clk_req),
  .wkreg_en     (wkreg_en),
  .off_mode_req (off_mode_req),
  .dom_pwr_on   (dom_pwr_on),
  .mem_reg_on   (mem_reg_on),
  .analog_on    (analog_on),
  .core_rst     (core_rst),
  .mpu_rst      (mpu_rst),
  .pad_normal   (pad_normal),
  .seq_done     (seq_done),
  .osc_exp      (osc_exp),
  .rail_exp     (rail_exp)
);

// File: tb/offwake_seq_bench.sv
`timescale 1ns/1ps
module offwake_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wake_evt = 1'b0, io_wake_en = 1'b1, io_chain_en = 1'b1;
  logic [15:0] osc_setup_cyc = '0, rail_setup_cyc = '0, rst_hold_cyc = '0, ramp_tmo_cyc = '0;
  logic        ramp_use_ack = 1'b0, ramp_ack = 1'b0, pad_ovr = 1'b1;
  logic        osc_en, clk_req, wkreg_en, off_mode_req, dom_pwr_on, mem_reg_on, analog_on;
  logic        core_rst, mpu_rst, pad_normal, seq_done;
  logic [2:0]  state_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  offwake_seq u_offwake_seq (
    .clk(clk), .rst(rst), .wake_evt(wake_evt), .io_wake_en(io_wake_en),
    .io_chain_en(io_chain_en), .osc_setup_cyc(osc_setup_cyc),
    .rail_setup_cyc(rail_setup_cyc), .rst_hold_cyc(rst_hold_cyc),
    .ramp_tmo_cyc(ramp_tmo_cyc), .ramp_use_ack(ramp_use_ack), .ramp_ack(ramp_ack),
    .pad_ovr(pad_ovr), .osc_en(osc_en), .clk_req(clk_req), .wkreg_en(wkreg_en),
    .off_mode_req(off_mode_req), .dom_pwr_on(dom_pwr_on), .mem_reg_on(mem_reg_on),
    .analog_on(analog_on), .core_rst(core_rst), .mpu_rst(mpu_rst),
    .pad_normal(pad_normal), .state_o(state_o), .seq_done(seq_done)
  );

  function automatic int win(input int n);
    if (n < 1) return 1;
    return n;
  endfunction

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Packed output word: osc,clkreq,wkreg,offreq,dompwr,mem,analog,core_rst,mpu_rst
  function automatic logic [8:0] outs();
    return {osc_en, clk_req, wkreg_en, off_mode_req, dom_pwr_on, mem_reg_on,
            analog_on, core_rst, mpu_rst};
  endfunction

  // Expected output word by state; hold_idx is the 1-based cycle within state 4.
  function automatic logic [8:0] expect_outs(input int st, input int hold_idx, input int rst_w);
    case (st)
      0: return 9'b000100011;
      1: return 9'b110100011;
      2: return 9'b111100011;
      3: return 9'b111000011;
      4: return (hold_idx >= rst_w) ? 9'b111011101 : 9'b111011111;
      5: return 9'b111011100;
      default: return 9'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    wake_evt = 1'b0;
    ramp_ack = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wake_pulse();
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(state_o == 3'd0, "R1", "state after reset", state_o, 0);
    chk(outs() == 9'b000100011, "R1", "outputs after reset", outs(), 9'b000100011);
    chk(!pad_normal && !seq_done, "R1", "pad/done after reset", {pad_normal, seq_done}, 0);
  endtask

  task automatic t_gate();
    for (int k = 0; k < 2; k++) begin
      do_reset();
      io_wake_en  = (k == 1);
      io_chain_en = (k == 0);
      wake_pulse();
      repeat (4) @(negedge clk);
      chk(state_o == 3'd0 && outs() == 9'b000100011, "R2", "wake with enable cleared",
          state_o, 0);
    end
    io_wake_en  = 1'b1;
    io_chain_en = 1'b1;
  endtask

  // Full sequence on the timeout ramp; counts cycles per state at the ports.
  task automatic t_seq(input int osc, input int rail, input int rh, input int rmp,
                       input bit busy_wake);
    int cnt[6];
    int bad_tbl = 0;
    int guard = 0;
    int done_early = 0;
    bit pwr_ok = 1'b1;
    logic [8:0] prev = '0;
    int prev_st = 0;
    osc_setup_cyc  = 16'(osc);
    rail_setup_cyc = 16'(rail);
    rst_hold_cyc   = 16'(rh);
    ramp_tmo_cyc   = 16'(rmp);
    ramp_use_ack   = 1'b0;
    pad_ovr        = 1'b1;
    foreach (cnt[i]) cnt[i] = 0;
    do_reset();
    wake_pulse();
    if (busy_wake) wake_evt = 1'b1;
    while (state_o != 3'd5 && guard < 5000) begin
      cnt[state_o]++;
      if (outs() != expect_outs(state_o, cnt[4], win(rh))) bad_tbl++;
      if (seq_done) done_early++;
      if (state_o == 3'd4 && prev_st == 3 &&
          !(dom_pwr_on && mem_reg_on && analog_on && mpu_rst && prev[4:2] == 3'b000))
        pwr_ok = 1'b0;
      if (state_o == 3'd3 && prev_st == 2 && prev[5] != 1'b1) pwr_ok = 1'b0;
      prev    = outs();
      prev_st = state_o;
      guard++;
      @(negedge clk);
    end
    chk(cnt[1] == 1, "R3", "oscillator-start cycles", cnt[1], 1);
    chk(cnt[2] == win(rmp), "R4", "ramp timeout cycles", cnt[2], win(rmp));
    chk(cnt[3] == maxi(win(osc), win(rail)), "R5", "settling cycles", cnt[3],
        maxi(win(osc), win(rail)));
    chk(cnt[4] == win(rh), "R8", "reset hold cycles", cnt[4], win(rh));
    chk(bad_tbl == 0, "R3", "per-state output levels", bad_tbl, 0);
    chk(pwr_ok, "R6", "power step into hold", pwr_ok, 1);
    chk(state_o == 3'd5 && outs() == 9'b111011100 && pad_normal, "R11",
        "running state code and outputs", state_o, 5);
    chk(seq_done && done_early == 0, "R9", "done on first running cycle", seq_done, 1);
    @(negedge clk);
    chk(!seq_done, "R9", "done drops after one cycle", seq_done, 0);
    wake_evt = 1'b1;
    repeat (4) @(negedge clk);
    chk(state_o == 3'd5 && !seq_done, "R10", "wake while running", state_o, 5);
    wake_evt = 1'b0;
  endtask

  task automatic t_ramp_ack();
    osc_setup_cyc  = 16'd2;
    rail_setup_cyc = 16'd2;
    rst_hold_cyc   = 16'd2;
    ramp_tmo_cyc   = 16'd3;
    ramp_use_ack   = 1'b1;
    pad_ovr        = 1'b1;
    do_reset();
    wake_pulse();
    @(negedge clk);
    repeat (20) @(negedge clk);
    chk(state_o == 3'd2 && off_mode_req, "R4", "ramp waits for acknowledge", state_o, 2);
    ramp_ack = 1'b1;
    @(negedge clk);
    ramp_ack = 1'b0;
    chk(state_o == 3'd3 && !off_mode_req, "R3", "off-mode released after acknowledge",
        state_o, 3);
    ramp_use_ack = 1'b0;
  endtask

  task automatic t_pad_hold();
    int guard = 0;
    osc_setup_cyc  = 16'd1;
    rail_setup_cyc = 16'd1;
    rst_hold_cyc   = 16'd3;
    ramp_tmo_cyc   = 16'd1;
    pad_ovr        = 1'b0;
    do_reset();
    wake_pulse();
    while (state_o != 3'd4 && guard < 100) begin
      guard++;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk(state_o == 3'd4 && !pad_normal, "R7", "pads stay off without override", pad_normal, 0);
    chk(!core_rst && mpu_rst, "R8", "core freed, processor held", {core_rst, mpu_rst}, 1);
    pad_ovr = 1'b1;
    @(negedge clk);
    chk(pad_normal && state_o == 3'd4 && mpu_rst, "R7", "pads restored after override",
        pad_normal, 1);
    @(negedge clk);
    chk(state_o == 3'd5 && !mpu_rst && seq_done, "R8", "processor reset released",
        mpu_rst, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_gate();
    t_seq(5, 12, 4, 3, 1'b0);
    t_seq(30, 3, 1, 0, 1'b0);
    t_seq(0, 0, 0, 0, 1'b0);
    t_seq(7, 9, 6, 2, 1'b1);
    t_ramp_ack();
    t_pad_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule